// File: doc/BRIEF.md
# Ramped BPSK Phase Controller

This block is the phase core of a numerically controlled oscillator with a binary phase-shift keying front end. A 48-bit phase accumulator advances by a registered tuning word on every clock. The top bits of the accumulator, plus a 14-bit keying offset, form the phase word that addresses a downstream sine table. The sine table, the converter and any amplitude shaping sit outside this block.

The keying offset does not jump between 0 and half a turn. It moves there in equal steps at a programmable rate. A fall from half a turn always walks back down through the same values that the rise used. The carrier therefore never gains a full extra turn, and its average frequency stays at the one the tuning word sets.

A symbol strobe carries the data bit. A strobe that repeats the current bit does nothing. A strobe that arrives while a ramp is running is held, and it is applied when the ramp has finished.

Top module: `bpsk_ramp_osc`

## Requirements
- R1: A synchronous reset clears the accumulator, the registered tuning word and the offset, sets the bit state to 0 and drops `busy`. After reset, `phase_out` and `offset_out` are both 0.
- R2: On every clock the accumulator adds the tuning word that was registered on the previous clock. A new `ftw` value is therefore first added at the second rising edge after it is presented.
- R3: `phase_out` equals accumulator bits [47:34] plus `offset_out`, modulo 2^14.
- R4: A rise from bit 0 to bit 1 moves `offset_out` from 0 up to 0x2000 (180 degrees) in steps of +64. With N = `ramp_len` + 1, where `ramp_len` is captured when the ramp starts, one step lands every N clocks. The first step comes N edges after the edge that accepts the strobe. The offset never goes past 0x2000.
- R5: A fall from bit 1 to bit 0 moves `offset_out` from 0x2000 down to 0 in steps of -64, at the same step period. It passes through the rise's values in reverse order.
- R6: `busy` rises on the edge that accepts a changing strobe. It stays high until the edge of the final step, which lands exactly on 0 or 0x2000. At all other times it is low.
- R7: A strobe whose bit equals the current bit state causes no ramp. `offset_out` and `busy` stay unchanged.
- R8: A strobe seen while `busy` is high is held. If several such strobes arrive, the latest one wins. The held strobe is acted on in the cycle after the ramp ends, and it is dropped if it matches the new state.
- R9: After any sequence of symbols that ends in bit 0, `offset_out` is 0 and `phase_out` equals the accumulator bits alone, so there is no net phase rotation.
- R10: A change of `ftw` during a ramp does not alter the values or the timing of the offset steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Symbol strobe |
| sym_bit | input | 1 | Data bit carried with the strobe |
| ftw | input | 48 | Frequency tuning word |
| ramp_len | input | 8 | Clocks per offset step, minus one |
| phase_out | output | 14 | Phase word for the sine table |
| offset_out | output | 14 | Current keying offset |
| busy | output | 1 | High while a ramp is running |

## Verification
The hardest situation to reach is a ramp finishing while a held strobe is waiting. Two orderings matter: a reversing strobe must start a second ramp right after the first one lands, and a strobe that matches the new state must be dropped. The stimulus reaches both by sending strobes a set number of cycles into a running ramp, including two opposite strobes in one ramp so that the latest one decides. A scoreboard queues every expected offset value together with its step spacing. A long run of random symbols with changing tuning words then checks that no offset remains at the end.

// File: rtl/bpsk_ramp_osc.sv
module bpsk_ramp_osc #(
  parameter int ACC_W   = 48,
  parameter int PH_W    = 14,
  parameter int STEP_SH = 6,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic             sym_bit,
  input  logic [ACC_W-1:0] ftw,
  input  logic [LEN_W-1:0] ramp_len,
  output logic [PH_W-1:0]  phase_out,
  output logic [PH_W-1:0]  offset_out,
  output logic             busy
);
  localparam logic [PH_W-1:0] HALF = PH_W'(1) << (PH_W - 1);
  localparam logic [PH_W-1:0] STEP = PH_W'(1) << STEP_SH;

  logic [ACC_W-1:0] ftw_q, acc_q;
  logic [PH_W-1:0]  off_q, off_nxt;
  logic [LEN_W-1:0] len_q, div_q;
  logic             busy_q, dir_q, cur_q, pend_v, pend_b;
  logic             req_v, req_b, start, step_now, land;

  assign req_v    = sym_valid | pend_v;
  assign req_b    = sym_valid ? sym_bit : pend_b;
  assign start    = !busy_q && req_v && (req_b != cur_q);
  assign step_now = busy_q && (div_q == len_q);
  assign off_nxt  = dir_q ? off_q + STEP : off_q - STEP;
  assign land     = off_nxt == (dir_q ? HALF : '0);

  assign phase_out  = acc_q[ACC_W-1 -: PH_W] + off_q;
  assign offset_out = off_q;
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_q  <= '0;
      acc_q  <= '0;
      off_q  <= '0;
      len_q  <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      cur_q  <= 1'b0;
      pend_v <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      ftw_q <= ftw;
      acc_q <= acc_q + ftw_q;

      if (!busy_q) pend_v <= 1'b0;
      else if (sym_valid) begin
        pend_v <= 1'b1;
        pend_b <= sym_bit;
      end

      if (start) begin
        busy_q <= 1'b1;
        dir_q  <= req_b;
        len_q  <= ramp_len;
        div_q  <= '0;
      end else if (step_now) begin
        off_q <= off_nxt;
        div_q <= '0;
        if (land) begin
          busy_q <= 1'b0;
          cur_q  <= dir_q;
        end
      end else if (busy_q) begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst) assert_offset_bounded_R4: assert (off_q <= HALF);

  assert_idle_offset_still_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(off_q));

  assert_step_size_R4: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(off_q) || (off_q - $past(off_q)) == STEP || ($past(off_q) - off_q) == STEP));

  assert_rise_never_falls_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dir_q) |=> (off_q >= $past(off_q)));

  assert_fall_never_rises_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !dir_q) |=> (off_q <= $past(off_q)));

  assert_busy_ends_on_endpoint_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (busy_q || off_q == '0 || off_q == HALF));
endmodule

// File: tb/bpsk_ramp_osc_tb_top.sv
module bpsk_ramp_osc_tb_top;
  logic        clk = 0, rst = 1, sym_valid = 0, sym_bit = 0;
  logic [47:0] ftw = '0;
  logic [7:0]  ramp_len = '0;
  logic [13:0] phase_out, offset_out;
  logic        busy;

  int errors = 0, checks = 0, cyc = 0;
  int exp_val[$], exp_gap[$];
  logic [47:0] ftw_m = '0, acc_m = '0;

  bpsk_ramp_osc dut_i (.clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bit(sym_bit),
    .ftw(ftw), .ramp_len(ramp_len), .phase_out(phase_out), .offset_out(offset_out), .busy(busy));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ftw_m <= rst ? '0 : ftw;
    acc_m <= rst ? '0 : acc_m + ftw_m;
  end

  // R2/R3 phase word against the accumulator model
  always @(negedge clk)
    if (!rst) chk(phase_out == 14'(acc_m[47:34] + offset_out), "R2/R3 phase",
                  phase_out, 14'(acc_m[47:34] + offset_out));

  // monitor: offset trajectory and step spacing
  logic [13:0] off_prev = '0;
  logic        bsy_prev = 0;
  int          gap = 0;
  always @(negedge clk) begin
    if (rst) begin
      off_prev = '0; bsy_prev = 0; gap = 0;
    end else begin
      gap++;
      if (busy && !bsy_prev) gap = 0;
      if (offset_out != off_prev) begin
        if (exp_val.size() == 0) chk(0, "R7/R8 unexpected step", offset_out, off_prev);
        else begin
          int v, g;
          v = exp_val.pop_front(); g = exp_gap.pop_front();
          chk(offset_out == 14'(v), "R4/R5 offset value", offset_out, v);
          chk(gap == g, "R4/R10 step spacing", gap, g);
        end
        gap = 0;
      end
      off_prev = offset_out;
      bsy_prev = busy;
    end
  end

  task automatic push_ramp(input bit up, input int n);
    for (int k = 1; k <= 128; k++) begin
      exp_val.push_back(up ? k * 64 : 8192 - k * 64);
      exp_gap.push_back(n);
    end
  endtask

  task automatic strobe(input bit b);
    @(negedge clk); sym_valid = 1; sym_bit = b;
    @(negedge clk); sym_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(0, "watchdog", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit st;
    ftw = 48'h1234_5678_9abc;
    repeat (4) @(negedge clk);
    chk(offset_out == 0 && phase_out == 0, "R1 reset outputs", phase_out, 0);
    chk(busy == 0, "R1 reset busy", busy, 0);
    rst = 0;
    idle_cycles(10);
    ftw = 48'h0100_0000_0000;
    idle_cycles(5);

    // R4 rise, N=3, with tuning word changes mid-ramp (R10)
    ramp_len = 2; push_ramp(1, 3); strobe(1);
    chk(busy == 1, "R6 busy after strobe", busy, 1);
    idle_cycles(50); ftw = 48'h0000_0fff_0000;
    idle_cycles(50); ftw = 48'hffff_0000_1111;
    wait_idle();
    chk(offset_out == 14'h2000, "R4 lands at 0x2000", offset_out, 14'h2000);
    chk(busy == 0, "R6 busy low at end", busy, 0);

    // R7 repeat of current bit
    strobe(1); idle_cycles(20);
    chk(busy == 0 && offset_out == 14'h2000, "R7 repeat ignored", offset_out, 14'h2000);

    // R5 fall, N=1
    ramp_len = 0; push_ramp(0, 1); strobe(0); wait_idle();
    chk(offset_out == 0, "R5 lands at 0", offset_out, 0);

    // R8 reversing strobe held mid-ramp
    ramp_len = 1; push_ramp(1, 2); push_ramp(0, 2);
    strobe(1); idle_cycles(30); strobe(0);
    chk(busy == 1, "R8 still ramping up", busy, 1);
    wait_idle(); idle_cycles(2); wait_idle();
    chk(offset_out == 0, "R8 held strobe applied", offset_out, 0);

    // R8 latest wins: 0 then 1 during a rise -> nothing after
    push_ramp(1, 2);
    strobe(1); idle_cycles(20); strobe(0); idle_cycles(5); strobe(1);
    wait_idle(); idle_cycles(10);
    chk(busy == 0 && offset_out == 14'h2000, "R8 latest strobe wins", offset_out, 14'h2000);
    ramp_len = 0; push_ramp(0, 1); strobe(0); wait_idle();

    // R9 long random sequence ending at bit 0
    st = 0;
    for (int i = 0; i < 40; i++) begin
      bit b;
      b = 1'($urandom);
      ftw = {$urandom, 16'($urandom)};
      ramp_len = 8'($urandom % 3);
      if (b != st) push_ramp(b, ramp_len + 1);
      st = b;
      strobe(b); wait_idle();
    end
    if (st) begin push_ramp(0, ramp_len + 1); strobe(0); wait_idle(); end
    idle_cycles(3);
    chk(offset_out == 0, "R9 no residual offset", offset_out, 0);
    chk(phase_out == acc_m[47:34], "R9 phase equals accumulator", phase_out, acc_m[47:34]);
    chk(exp_val.size() == 0, "R4/R5 all expected steps seen", exp_val.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule